// File: doc/BRIEF.md
# Vectored Interrupt Controller with Bus-Mapped Trigger Window

This block sits beside a small processor core on its load/store bus and arbitrates between 64 interrupt numbers. Numbers 0x00–0x0F are for processor events. Numbers 0x10–0x1F are raised by software, and 0x10 is the cross interrupt between the graphics engine and the processor. Numbers 0x20–0x3F belong to devices: 0x20 is the touchscreen and 0x21 is the keyboard.

An interrupt becomes pending in one of two ways. Software can store to a slot of a write-only trigger window, or a hardware request line can rise. The controller keeps a programmable jump target for each number in a vector table. It blocks numbers through a 64-bit mask, which is split into four 16-bit words. It also blocks everything while the interrupts-masked flag is set.

The controller always offers the lowest-numbered pending, unmasked interrupt to the core, together with that number's vector. When the core acknowledges, the controller does three things on the same clock edge:
- it records the core's return address in a read-only register;
- it sets the interrupts-masked flag;
- it retires the pending bit.

The handler later clears the flag with a bus store to return to normal operation.

Top module: `intc_top`

## Requirements
- R1: After reset, `irq_req` is low, no interrupt is pending, all four mask words read 0x0000, the flags register reads 0x0010 (interrupts masked), and the saved return address reads 0x0000.
- R2: Address 0x1000+n (n = 0..63) reads and writes the 16-bit vector table entry for interrupt n.
- R3: A bus write to 0x1040+n makes interrupt n pending from the next clock edge, whatever data is written. A read anywhere in 0x1040–0x107F returns 0x0000.
- R4: A 0-to-1 transition on `hw_req[n]` makes interrupt n pending on the following clock edge. A line held high does not make n pending again after it has been acknowledged.
- R5: The mask word at 0x1080+i is read/write. Its bit j blocks interrupt 16*i+j when it is 1. A blocked interrupt stays pending, and it is offered once its mask bit returns to 0.
- R6: The flags register at 0x1084 is read/write. Bit 0 is zero, bit 1 is negative, bit 2 is carry, bit 3 is overflow and bit 4 is interrupts-masked. Bits 15:5 read as 0.
- R7: `irq_req` is high exactly when at least one interrupt is both pending and unmasked and flag bit 4 is 0. When it is high, `irq_num` is the lowest such number and `irq_vector` is that number's vector table entry.
- R8: An acknowledge is `irq_ack` high on a clock edge while `irq_req` is high. On that edge the block clears pending bit `irq_num`, copies `core_pc` into the saved return address and sets flag bit 4. When `irq_req` is low, `irq_ack` changes nothing.
- R9: The saved return address reads at 0x1085. Bus writes to that address leave it unchanged.
- R10: Two events may fall on the same edge as an acknowledge:
  - a trigger write for the acknowledged number leaves that number pending;
  - a flags write leaves flag bit 4 set, while bits 3:0 take the written data.
- R11: Reads of addresses outside the mapped regions return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Word address of the bus access |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| hw_req | input | 64 | Hardware request lines, one per interrupt number, edge-sensitive |
| core_pc | input | 16 | Return address offered by the core for saving on acknowledge |
| irq_ack | input | 1 | Core accepts the offered interrupt |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_num | output | 6 | Number of the offered interrupt |
| irq_vector | output | 16 | Vector table entry of the offered interrupt |

## Verification
Two of the block's functions can land on one clock edge: retiring an acknowledged interrupt, and a fresh bus event that touches the same state. The bench provokes two such collisions.

In the first, it drives `irq_ack` together with a trigger write for the very number being acknowledged. It then clears the masked flag and expects that number to be offered again, because setting a pending bit must win over clearing it.

In the second, it acknowledges while storing to the flags register. It judges the result by reading the flags back: bit 4 must be set, because the acknowledge wins, and the condition bits must hold the stored data.

// File: rtl/intc_pkg.sv
// Shared definitions for the interrupt controller: the address regions
// the decoder can recognise and the bit layout of the flags register.
package intc_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_VEC,
        RG_TRIG,
        RG_MASK,
        RG_FLAGS,
        RG_SIP
    } region_e;

    localparam int FLG_ZERO   = 0;
    localparam int FLG_NEG    = 1;
    localparam int FLG_CARRY  = 2;
    localparam int FLG_OVF    = 3;
    localparam int FLG_MASKED = 4;
    localparam int FLAG_BITS  = 5;

endpackage

// File: rtl/intc_decode.sv
// Address decoder. It classifies a bus address into one of the
// controller's regions and returns the offset inside that region.
// Assumes that the regions do not overlap and that each one has at most
// NUM_IRQ words.
module intc_decode
    import intc_pkg::*;
#(
    parameter int              NUM_IRQ    = 64,
    parameter int              DATA_W     = 16,
    parameter int              ADDR_W     = 16,
    parameter logic [15:0]     VEC_BASE   = 16'h1000,
    parameter logic [15:0]     TRIG_BASE  = 16'h1040,
    parameter logic [15:0]     MASK_BASE  = 16'h1080,
    parameter logic [15:0]     FLAG_ADDR  = 16'h1084,
    parameter logic [15:0]     SIP_ADDR   = 16'h1085
) (
    input  logic [ADDR_W-1:0]          addr,
    output region_e                    region,
    output logic [$clog2(NUM_IRQ)-1:0] off
);
    localparam int IDX_W      = $clog2(NUM_IRQ);
    localparam int MASK_WORDS = NUM_IRQ / DATA_W;

    logic [ADDR_W-1:0] d_vec, d_trig, d_mask;

    // Distance of the address from each region base.
    always_comb begin
        d_vec  = addr - ADDR_W'(VEC_BASE);
        d_trig = addr - ADDR_W'(TRIG_BASE);
        d_mask = addr - ADDR_W'(MASK_BASE);
    end

    // Region selection: flags and saved IP first, then the windows.
    always_comb begin
        region = RG_NONE;
        off    = '0;
        if (addr == ADDR_W'(FLAG_ADDR)) begin
            region = RG_FLAGS;
        end else if (addr == ADDR_W'(SIP_ADDR)) begin
            region = RG_SIP;
        end else if (addr >= ADDR_W'(VEC_BASE) && d_vec < ADDR_W'(NUM_IRQ)) begin
            region = RG_VEC;
            off    = d_vec[IDX_W-1:0];
        end else if (addr >= ADDR_W'(TRIG_BASE) && d_trig < ADDR_W'(NUM_IRQ)) begin
            region = RG_TRIG;
            off    = d_trig[IDX_W-1:0];
        end else if (addr >= ADDR_W'(MASK_BASE) && d_mask < ADDR_W'(MASK_WORDS)) begin
            region = RG_MASK;
            off    = d_mask[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/intc_pending.sv
// Pending-bit store. A bit is set by a trigger write or by a rising edge
// on its hardware request line, and cleared by an acknowledge. On the
// same edge, setting beats clearing. Request lines are assumed to be
// synchronous to clk already.
module intc_pending #(
    parameter int NUM_IRQ = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IRQ-1:0]         hw_req,
    input  logic                       trig_fire,
    input  logic [$clog2(NUM_IRQ)-1:0] trig_idx,
    input  logic                       clr_fire,
    input  logic [$clog2(NUM_IRQ)-1:0] clr_idx,
    output logic [NUM_IRQ-1:0]         pend_q,
    output logic [NUM_IRQ-1:0]         set_vec
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] prev_q;
    logic [NUM_IRQ-1:0] trig_dec;
    logic [NUM_IRQ-1:0] clr_dec;

    // One-hot decode of the trigger and clear indices, one bit per number.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_dec
        assign trig_dec[g] = trig_fire && (trig_idx == IDX_W'(g));
        assign clr_dec[g]  = clr_fire  && (clr_idx  == IDX_W'(g));
    end

    // Setting events for this cycle: rising request edges plus the trigger.
    assign set_vec = (hw_req & ~prev_q) | trig_dec;

    // Update the edge-detect history and the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= hw_req;
            pend_q <= (pend_q & ~clr_dec) | set_vec;
        end
    end

endmodule

// File: rtl/intc_prio.sv
// Fixed-priority selector. It finds the lowest set bit of the eligible
// vector and returns that bit's index and a found flag. Purely
// combinational.
module intc_prio #(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]         elig,
    output logic                       any,
    output logic [$clog2(NUM_IRQ)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    // Scan from the top down so that the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

    // Any eligible interrupt at all.
    assign any = |elig;

endmodule

// File: rtl/intc_csr.sv
// Software-visible state: the vector table, the mask words, the flags
// and the saved return address, plus the bus read multiplexer. An
// acknowledge has priority over a flags write for the masked bit.
// Assumes NUM_IRQ is a multiple of DATA_W.
module intc_csr
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int DATA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  region_e                    region,
    input  logic [$clog2(NUM_IRQ)-1:0] off,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       ack_fire,
    input  logic [DATA_W-1:0]          core_pc,
    input  logic [$clog2(NUM_IRQ)-1:0] vec_sel,
    output logic [DATA_W-1:0]          vec_out,
    output logic [NUM_IRQ-1:0]         mask_flat,
    output logic                       masked_q,
    output logic [DATA_W-1:0]          sip_q,
    output logic [DATA_W-1:0]          rdata
);
    localparam int IDX_W      = $clog2(NUM_IRQ);
    localparam int MASK_WORDS = NUM_IRQ / DATA_W;

    logic [DATA_W-1:0]    vec_q  [NUM_IRQ];
    logic [DATA_W-1:0]    mask_q [MASK_WORDS];
    logic [FLG_OVF:0]     cond_q;

    // Vector table storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) vec_q[i] <= '0;
        end else if (wr_en && region == RG_VEC) begin
            vec_q[off] <= wdata;
        end
    end

    // Mask words, one register per word, flattened to one bit per number.
    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w] <= '0;
            end else if (wr_en && region == RG_MASK && off == IDX_W'(w)) begin
                mask_q[w] <= wdata;
            end
        end
        assign mask_flat[w*DATA_W +: DATA_W] = mask_q[w];
    end

    // Condition flags follow bus writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (wr_en && region == RG_FLAGS) begin
            cond_q <= wdata[FLG_OVF:0];
        end
    end

    // Masked flag: set at reset and on acknowledge, otherwise bus-writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked_q <= 1'b1;
        end else if (ack_fire) begin
            masked_q <= 1'b1;
        end else if (wr_en && region == RG_FLAGS) begin
            masked_q <= wdata[FLG_MASKED];
        end
    end

    // Saved return address, loaded only by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sip_q <= '0;
        end else if (ack_fire) begin
            sip_q <= core_pc;
        end
    end

    // Vector of the interrupt currently selected by the priority logic.
    assign vec_out = vec_q[vec_sel];

    // Bus read multiplexer; write-only and unmapped locations read zero.
    always_comb begin
        rdata = '0;
        case (region)
            RG_VEC:   rdata = vec_q[off];
            RG_MASK:  rdata = mask_q[off[$clog2(MASK_WORDS > 1 ? MASK_WORDS : 2)-1:0]];
            RG_FLAGS: rdata = DATA_W'({masked_q, cond_q});
            RG_SIP:   rdata = sip_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_top.sv
// Top of the vectored interrupt controller. It connects the decoder, the
// pending store, the priority selector and the register file. It offers
// the lowest pending, unmasked interrupt while the masked flag is clear.
// Assumes single-cycle bus writes and a core that acknowledges only the
// interrupt currently offered.
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]         hw_req,
    input  logic [DATA_W-1:0]          core_pc,
    input  logic                       irq_ack,
    output logic                       irq_req,
    output logic [$clog2(NUM_IRQ)-1:0] irq_num,
    output logic [DATA_W-1:0]          irq_vector
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    region_e            region;
    logic [IDX_W-1:0]   dec_off;
    logic               trig_fire;
    logic               ack_fire;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] mask_flat;
    logic [NUM_IRQ-1:0] elig;
    logic               any_elig;
    logic [IDX_W-1:0]   win_idx;
    logic               masked_q;
    logic [DATA_W-1:0]  sip_q;

    intc_decode #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .off    (dec_off)
    );

    // Trigger writes and accepted acknowledges.
    assign trig_fire = bus_wr && region == RG_TRIG;
    assign ack_fire  = irq_ack && irq_req;

    intc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req    (hw_req),
        .trig_fire (trig_fire),
        .trig_idx  (dec_off),
        .clr_fire  (ack_fire),
        .clr_idx   (win_idx),
        .pend_q    (pend_q),
        .set_vec   (set_vec)
    );

    // Only unmasked pending numbers compete.
    assign elig = pend_q & ~mask_flat;

    intc_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .elig (elig),
        .any  (any_elig),
        .idx  (win_idx)
    );

    intc_csr #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .region    (region),
        .off       (dec_off),
        .wdata     (bus_wdata),
        .ack_fire  (ack_fire),
        .core_pc   (core_pc),
        .vec_sel   (win_idx),
        .vec_out   (irq_vector),
        .mask_flat (mask_flat),
        .masked_q  (masked_q),
        .sip_q     (sip_q),
        .rdata     (bus_rdata)
    );

    // Request to the core, gated by the global masked flag.
    assign irq_req = any_elig && !masked_q;
    assign irq_num = win_idx;

endmodule

// File: rtl/intc_checker.sv
// Assertion checker for intc_top, attached by bind. It observes the
// pending store, the mask, the flags and the saved return address
// against the offered request.
module intc_checker #(
    parameter int NUM_IRQ = 64,
    parameter int DATA_W  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq_req,
    input logic [$clog2(NUM_IRQ)-1:0] irq_num,
    input logic                       irq_ack,
    input logic [DATA_W-1:0]          core_pc,
    input logic                       masked,
    input logic [DATA_W-1:0]          sip,
    input logic [NUM_IRQ-1:0]         pend,
    input logic [NUM_IRQ-1:0]         mask,
    input logic [NUM_IRQ-1:0]         set_vec,
    input logic                       trig_fire,
    input logic [$clog2(NUM_IRQ)-1:0] trig_idx
);
    logic [NUM_IRQ-1:0] below;

    // Numbers strictly below the offered one.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) below[i] = (i < int'(irq_num));
    end

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !masked);

    assert_num_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[irq_num] && !mask[irq_num]));

    assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((pend & ~mask & below) == '0));

    assert_ack_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (sip == $past(core_pc) && masked));

    assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !set_vec[irq_num]) |=> !pend[$past(irq_num)]);

    assert_sip_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_req) |=> $stable(sip));

    assert_trigger_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |=> pend[$past(trig_idx)]);

endmodule

bind intc_top intc_checker #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_num   (irq_num),
    .irq_ack   (irq_ack),
    .core_pc   (core_pc),
    .masked    (masked_q),
    .sip       (sip_q),
    .pend      (pend_q),
    .mask      (mask_flat),
    .set_vec   (set_vec),
    .trig_fire (trig_fire),
    .trig_idx  (dec_off)
);

// File: tb/tb_intc_top.sv
// Directed bench for intc_top: one task per scenario, each checking itself.
module tb_intc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] hw_req = '0;
    logic [15:0] core_pc = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [5:0]  irq_num;
    logic [15:0] irq_vector;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] exp_sip = '0;

    always #2 clk = ~clk;

    intc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_req(hw_req),
        .core_pc(core_pc), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_num(irq_num), .irq_vector(irq_vector)
    );

    function automatic logic [15:0] vec_of(input int n);
        return 16'h4000 + 16'(n * 4);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input logic [15:0] pc);
        @(negedge clk);
        core_pc = pc; irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        exp_sip = pc;
    endtask

    task automatic ack_unmask(input logic [15:0] pc);
        ack(pc);
        bus_write(16'h1084, 16'h0000);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1", "irq_req", {15'd0, irq_req}, 16'h0001 & 16'h0000);
        bus_read(16'h1084, d); check("R1", "flags", d, 16'h0010);
        for (int i = 0; i < 4; i++) begin
            bus_read(16'h1080 + 16'(i), d); check("R1", "mask word", d, 16'h0000);
        end
        bus_read(16'h1085, d); check("R1", "saved ip", d, 16'h0000);
    endtask

    task automatic t_vectors;
        logic [15:0] d;
        for (int n = 0; n < 64; n++) bus_write(16'h1000 + 16'(n), vec_of(n));
        bus_read(16'h1000, d); check("R2", "vec0", d, vec_of(0));
        bus_read(16'h1010, d); check("R2", "vec16", d, vec_of(16));
        bus_read(16'h103F, d); check("R2", "vec63", d, vec_of(63));
    endtask

    task automatic t_trigger;
        logic [15:0] d;
        bus_write(16'h1084, 16'h0000);
        check("R7", "no req before trigger", {15'd0, irq_req}, 16'h0000);
        bus_write(16'h1045, 16'h0000);
        check("R3", "req after trigger", {15'd0, irq_req}, 16'h0001);
        check("R7", "num", {10'd0, irq_num}, 16'd5);
        check("R7", "vector", irq_vector, vec_of(5));
        bus_read(16'h1045, d); check("R3", "trigger slot reads", d, 16'h0000);
        bus_read(16'h107F, d); check("R3", "last trigger slot reads", d, 16'h0000);
        ack(16'h1234);
        check("R8", "req after ack", {15'd0, irq_req}, 16'h0000);
        bus_read(16'h1084, d); check("R8", "flags after ack", d, 16'h0010);
        bus_read(16'h1085, d); check("R8", "saved ip", d, 16'h1234);
        bus_write(16'h1084, 16'h0000);
        check("R8", "pending retired", {15'd0, irq_req}, 16'h0000);
    endtask

    task automatic t_priority;
        bus_write(16'h1040 + 16'd40, 16'h0);
        bus_write(16'h1040 + 16'd7, 16'h0);
        bus_write(16'h1040 + 16'd20, 16'h0);
        check("R7", "lowest first", {10'd0, irq_num}, 16'd7);
        check("R7", "lowest vector", irq_vector, vec_of(7));
        ack_unmask(16'h0100);
        check("R7", "second", {10'd0, irq_num}, 16'd20);
        ack_unmask(16'h0200);
        check("R7", "third", {10'd0, irq_num}, 16'd40);
        ack_unmask(16'h0300);
        check("R7", "drained", {15'd0, irq_req}, 16'h0000);
    endtask

    task automatic t_mask;
        logic [15:0] d;
        bus_write(16'h1081, 16'h0002);
        bus_read(16'h1081, d); check("R5", "mask readback", d, 16'h0002);
        bus_write(16'h1040 + 16'd17, 16'h0);
        check("R5", "masked not offered", {15'd0, irq_req}, 16'h0000);
        bus_write(16'h1040 + 16'd18, 16'h0);
        check("R5", "neighbour offered", {10'd0, irq_num}, 16'd18);
        ack_unmask(16'h0400);
        check("R5", "still blocked", {15'd0, irq_req}, 16'h0000);
        bus_write(16'h1081, 16'h0000);
        check("R5", "unmasked offered", {10'd0, irq_num}, 16'd17);
        check("R5", "unmasked req", {15'd0, irq_req}, 16'h0001);
        ack_unmask(16'h0500);
    endtask

    task automatic t_hw;
        @(negedge clk); hw_req[33] = 1'b1;
        @(negedge clk);
        check("R4", "edge pends", {15'd0, irq_req}, 16'h0001);
        check("R4", "edge num", {10'd0, irq_num}, 16'd33);
        ack_unmask(16'h0600);
        @(negedge clk);
        check("R4", "level does not repend", {15'd0, irq_req}, 16'h0000);
        hw_req[33] = 1'b0;
        @(negedge clk); hw_req[33] = 1'b1;
        @(negedge clk);
        check("R4", "new edge pends", {10'd0, irq_num}, 16'd33);
        ack_unmask(16'h0700);
        hw_req[33] = 1'b0;
    endtask

    task automatic t_flags;
        logic [15:0] d;
        bus_write(16'h1084, 16'h000F);
        bus_read(16'h1084, d); check("R6", "cond bits", d, 16'h000F);
        bus_write(16'h1084, 16'hFFFF);
        bus_read(16'h1084, d); check("R6", "upper bits zero", d, 16'h001F);
        bus_write(16'h1084, 16'h0000);
    endtask

    task automatic t_sip_ro;
        logic [15:0] d;
        bus_write(16'h1085, 16'hBEEF);
        bus_read(16'h1085, d); check("R9", "saved ip write ignored", d, exp_sip);
    endtask

    task automatic t_idle_ack;
        logic [15:0] d;
        ack(16'h7777);
        exp_sip = 16'h0700;
        bus_read(16'h1085, d); check("R8", "idle ack keeps ip", d, 16'h0700);
        bus_read(16'h1084, d); check("R8", "idle ack keeps flags", d, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] d;
        bus_write(16'h1040 + 16'd9, 16'h0);
        check("R10", "offered 9", {10'd0, irq_num}, 16'd9);
        @(negedge clk);
        bus_addr = 16'h1040 + 16'd9; bus_wr = 1'b1; core_pc = 16'h0900; irq_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; irq_ack = 1'b0; exp_sip = 16'h0900;
        bus_write(16'h1084, 16'h0000);
        check("R10", "retrigger survives", {15'd0, irq_req}, 16'h0001);
        check("R10", "retrigger num", {10'd0, irq_num}, 16'd9);
        ack_unmask(16'h0A00);
        bus_write(16'h1040 + 16'd3, 16'h0);
        @(negedge clk);
        bus_addr = 16'h1084; bus_wdata = 16'h0001; bus_wr = 1'b1;
        core_pc = 16'h0B00; irq_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; irq_ack = 1'b0; exp_sip = 16'h0B00;
        bus_read(16'h1084, d); check("R10", "ack beats flag write", d, 16'h0011);
        bus_write(16'h1084, 16'h0000);
        check("R10", "3 retired", {15'd0, irq_req}, 16'h0000);
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        bus_read(16'h0000, d); check("R11", "addr 0000", d, 16'h0000);
        bus_read(16'h1090, d); check("R11", "addr 1090", d, 16'h0000);
        bus_read(16'h2000, d); check("R11", "addr 2000", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vectors();
        t_trigger();
        t_priority();
        t_mask();
        t_hw();
        t_flags();
        t_sip_ro();
        t_idle_ack();
        t_collide();
        t_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule